// File: doc/BRIEF.md
# I2C Burst Transaction Sequencer

This block runs a whole short I2C transfer, a write or a read of 1 to 8 bytes, from a single write to its control word. It needs no software action for each byte. Software first loads up to 64 bits of outgoing data into two 32-bit words, little-endian. It then writes the control word, which carries the direction, the target address, the 10-bit address flag, the byte count minus one and an enable bit. The sequencer then issues START, address, data and STOP commands one at a time to a byte-level bus engine. It collects received bytes into two 32-bit result words and raises a single completion cause, with an error flag, when the STOP has gone out.

The sequencer is a state machine with states IDLE, START, ADDR1, ADDR2, RESTART, ADDR1R, TX, RX and STOP. Each state other than IDLE issues one engine command and then waits for that command's response. The transitions are:
- IDLE→START when a valid start word is written.
- START→ADDR1.
- ADDR1→ADDR2 for a 10-bit address, →RX for a 7-bit read, →TX for a 7-bit write, or →STOP on a NACK.
- ADDR2→RESTART for a read, →TX for a write, or →STOP on a NACK.
- RESTART→ADDR1R.
- ADDR1R→RX, or →STOP on a NACK.
- TX→TX for the next byte, →STOP after the last byte or on a NACK.
- RX→RX for the next byte, or →STOP after the last byte.
- STOP→IDLE, which also raises the completion cause.

Software ends each message by writing zero to the control word and to the cause word.

Top module: `i2c_burst_offload`

## Requirements
- R1: After reset, every readable register reads zero, `irq` is low and no engine command is issued.
- R2: A write to the control word (offset 0xD0) starts a transfer only when the sequencer is idle, enable (bit 19) is set and exactly one of write-request (bit 0) or read-request (bit 1) is set. Any other control write issues no command and leaves the cause and status words unchanged.
- R3: A write transfer issues commands in this order: START, then WRITE of {addr[6:0],0}, then N data WRITEs, then STOP. N is bits 15:13 plus one. Data byte k is taken from bits 8k+7:8k of the transmit words: low word at 0xC0 for k<4, high word at 0xC4 for k≥4.
- R4: A read transfer issues START, then WRITE of {addr[6:0],1}, then N READ commands with NACK flagged only on the last, then STOP. N is bits 18:16 plus one. Received byte k is stored little-endian in the result words (low at 0xC8, high at 0xCC). Result bytes not received in this transfer read zero.
- R5: With bit 12 set, the 10-bit address is bits 11:2. A write sends 0xF0|(a[9:8]<<1) and then a[7:0]. A read sends the same two bytes, then a repeated START, then 0xF1|(a[9:8]<<1).
- R6: A NACK on any address or data byte the sequencer sends causes STOP to be the next command. After completion, status bit 0 (offset 0xD4) is then 1. A transfer that sees no NACK leaves it 0. Status is cleared when a transfer starts.
- R7: Completion sets cause bit 0 (offset 0xD8). `irq` equals cause bit 0 AND mask bit 0 (offset 0xDC). Writing 0 to the cause word clears it.
- R8: Control writes while a transfer runs are ignored: the command stream continues unchanged and the control word reads back its earlier value.
- R9: Writes to the transmit words while a transfer runs are ignored.
- R10: Engine commands are `eng_cmd_valid` pulses of one cycle. Op codes are START=1, WRITE=2, READ=3 and STOP=4, and `eng_cmd_byte` is 0 for every op except WRITE. No new command is issued until `eng_rsp_valid` answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Completion interrupt (cause AND mask) |
| eng_cmd_valid | output | 1 | One-cycle command strobe to the bus engine |
| eng_cmd_op | output | 3 | Command op: 1 START, 2 WRITE, 3 READ, 4 STOP |
| eng_cmd_byte | output | 8 | Byte to send for WRITE |
| eng_cmd_nack | output | 1 | For READ: answer the byte with NACK |
| eng_rsp_valid | input | 1 | One-cycle response from the engine |
| eng_rsp_ack | input | 1 | For WRITE: the target acknowledged |
| eng_rsp_byte | input | 8 | For READ: the byte received |

## Verification
The case hardest to reach from the ports is a control or transmit-word write that lands while a command is outstanding in the middle of a transfer. It must neither change the command stream nor change the stored words. The bench's engine model answers each command a fixed number of cycles after it is issued, so the bench knows the transfer is still running a few cycles after start. It writes conflicting values at that point and reads them back before the STOP. The engine model also NACKs a chosen write-type byte, which drives both the data-NACK path and the address-NACK path of a read.

// File: rtl/i2cbo_pkg.sv
package i2cbo_pkg;
    localparam int LEN_W    = 3;
    localparam int NBYTES   = 1 << LEN_W;
    localparam int NWORDS   = NBYTES / 4;
    localparam int ADDR_W   = 10;
    localparam int CTRL_W   = 20;

    localparam int CB_WR    = 0;
    localparam int CB_RD    = 1;
    localparam int CB_ADDR  = 2;
    localparam int CB_TEN   = 12;
    localparam int CB_TXLEN = 13;
    localparam int CB_RXLEN = 16;
    localparam int CB_EN    = 19;

    localparam int OFF_TX    = 'hC0;
    localparam int OFF_RX    = 'hC8;
    localparam int OFF_CTRL  = 'hD0;
    localparam int OFF_STAT  = 'hD4;
    localparam int OFF_CAUSE = 'hD8;
    localparam int OFF_MASK  = 'hDC;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_STOP  = 3'd4
    } eng_op_t;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR1, S_ADDR2, S_RESTART,
        S_ADDR1R, S_TX, S_RX, S_STOP
    } seq_state_t;

    function automatic logic [7:0] ten_hdr(input logic [1:0] hi, input logic rd);
        return {5'b11110, hi, rd};
    endfunction
endpackage

// File: rtl/i2cbo_seq.sv
module i2cbo_seq
    import i2cbo_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                go_rd,
    input  logic                go_ten,
    input  logic [ADDR_W-1:0]   go_addr,
    input  logic [LEN_W-1:0]    go_len,
    input  logic [8*NBYTES-1:0] tx_bytes,
    output logic                cmd_valid,
    output logic [2:0]          cmd_op,
    output logic [7:0]          cmd_byte,
    output logic                cmd_nack,
    input  logic                rsp_valid,
    input  logic                rsp_ack,
    input  logic [7:0]          rsp_byte,
    output logic                rx_we,
    output logic [LEN_W-1:0]    rx_idx,
    output logic [7:0]          rx_byte,
    output logic                done,
    output logic                fail,
    output logic                busy
);
    seq_state_t        state, nxt;
    logic              pend;
    logic [LEN_W-1:0]  idx, len_q;
    logic              rd_q, ten_q, err_q;
    logic [ADDR_W-1:0] addr_q;
    logic              step, last;

    assign step = pend && rsp_valid;
    assign last = (idx == len_q);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (go) nxt = S_START;
            S_START:   if (step) nxt = S_ADDR1;
            S_ADDR1:   if (step) begin
                           if (!rsp_ack)   nxt = S_STOP;
                           else if (ten_q) nxt = S_ADDR2;
                           else if (rd_q)  nxt = S_RX;
                           else            nxt = S_TX;
                       end
            S_ADDR2:   if (step) begin
                           if (!rsp_ack)  nxt = S_STOP;
                           else if (rd_q) nxt = S_RESTART;
                           else           nxt = S_TX;
                       end
            S_RESTART: if (step) nxt = S_ADDR1R;
            S_ADDR1R:  if (step) nxt = rsp_ack ? S_RX : S_STOP;
            S_TX:      if (step && (!rsp_ack || last)) nxt = S_STOP;
            S_RX:      if (step && last) nxt = S_STOP;
            S_STOP:    if (step) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            pend   <= 1'b0;
            idx    <= '0;
            len_q  <= '0;
            rd_q   <= 1'b0;
            ten_q  <= 1'b0;
            err_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            state <= nxt;
            if (cmd_valid)
                pend <= 1'b1;
            else if (rsp_valid)
                pend <= 1'b0;
            if (go && state == S_IDLE) begin
                idx    <= '0;
                len_q  <= go_len;
                rd_q   <= go_rd;
                ten_q  <= go_ten;
                addr_q <= go_addr;
                err_q  <= 1'b0;
            end else if (step) begin
                unique case (state)
                    S_ADDR1, S_ADDR2, S_ADDR1R:
                        if (!rsp_ack) err_q <= 1'b1;
                    S_TX: begin
                        if (!rsp_ack) err_q <= 1'b1;
                        else if (!last) idx <= idx + 1'b1;
                    end
                    S_RX:
                        if (!last) idx <= idx + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        cmd_valid = busy && !pend;
        cmd_op    = OP_NONE;
        cmd_byte  = '0;
        cmd_nack  = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_START, S_RESTART:
                cmd_op = OP_START;
            S_ADDR1: begin
                cmd_op   = OP_WRITE;
                cmd_byte = ten_q ? ten_hdr(addr_q[9:8], 1'b0) : {addr_q[6:0], rd_q};
            end
            S_ADDR2: begin
                cmd_op   = OP_WRITE;
                cmd_byte = addr_q[7:0];
            end
            S_ADDR1R: begin
                cmd_op   = OP_WRITE;
                cmd_byte = ten_hdr(addr_q[9:8], 1'b1);
            end
            S_TX: begin
                cmd_op   = OP_WRITE;
                cmd_byte = tx_bytes[{idx, 3'b000} +: 8];
            end
            S_RX: begin
                cmd_op   = OP_READ;
                cmd_nack = last;
            end
            S_STOP:
                cmd_op = OP_STOP;
            default: ;
        endcase
        rx_we   = step && (state == S_RX);
        rx_idx  = idx;
        rx_byte = rsp_byte;
        done    = step && (state == S_STOP);
        fail    = done && err_q;
    end
endmodule

// File: rtl/i2cbo_regs.sv
module i2cbo_regs
    import i2cbo_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic                busy,
    input  logic                rx_we,
    input  logic [LEN_W-1:0]    rx_idx,
    input  logic [7:0]          rx_byte,
    input  logic                done,
    input  logic                fail,
    output logic                go,
    output logic                go_rd,
    output logic                go_ten,
    output logic [ADDR_W-1:0]   go_addr,
    output logic [LEN_W-1:0]    go_len,
    output logic [8*NBYTES-1:0] tx_bytes,
    output logic [CTRL_W-1:0]   ctrl_q,
    output logic                cause_q,
    output logic                irq
);
    logic [31:0] tx_w [NWORDS];
    logic [7:0]  rx_b [NBYTES];
    logic        err_q, mask_q, wr_ctrl, kick;

    assign wr_ctrl = we && (addr == AW'(OFF_CTRL));
    assign kick    = wdata[CB_EN] && (wdata[CB_WR] ^ wdata[CB_RD]);
    assign go      = wr_ctrl && !busy && kick;
    assign go_rd   = wdata[CB_RD];
    assign go_ten  = wdata[CB_TEN];
    assign go_addr = wdata[CB_ADDR +: ADDR_W];
    assign go_len  = wdata[CB_RD] ? wdata[CB_RXLEN +: LEN_W] : wdata[CB_TXLEN +: LEN_W];
    assign irq     = cause_q && mask_q;

    for (genvar w = 0; w < NWORDS; w++) begin : g_pack
        assign tx_bytes[32*w +: 32] = tx_w[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            err_q   <= 1'b0;
            cause_q <= 1'b0;
            mask_q  <= 1'b0;
            for (int w = 0; w < NWORDS; w++) tx_w[w] <= '0;
            for (int b = 0; b < NBYTES; b++) rx_b[b] <= '0;
        end else begin
            if (wr_ctrl && !busy)
                ctrl_q <= wdata[CTRL_W-1:0];
            for (int w = 0; w < NWORDS; w++)
                if (we && !busy && addr == AW'(OFF_TX + 4*w))
                    tx_w[w] <= wdata;
            if (go) begin
                for (int b = 0; b < NBYTES; b++) rx_b[b] <= '0;
            end else if (rx_we) begin
                rx_b[rx_idx] <= rx_byte;
            end
            if (go)
                err_q <= 1'b0;
            else if (done)
                err_q <= fail;
            if (done)
                cause_q <= 1'b1;
            else if (we && addr == AW'(OFF_CAUSE))
                cause_q <= wdata[0];
            if (we && addr == AW'(OFF_MASK))
                mask_q <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFF_CTRL))  rdata[CTRL_W-1:0] = ctrl_q;
        if (addr == AW'(OFF_STAT))  rdata[0] = err_q;
        if (addr == AW'(OFF_CAUSE)) rdata[0] = cause_q;
        if (addr == AW'(OFF_MASK))  rdata[0] = mask_q;
        for (int w = 0; w < NWORDS; w++) begin
            if (addr == AW'(OFF_TX + 4*w)) rdata = tx_w[w];
            if (addr == AW'(OFF_RX + 4*w))
                rdata = {rx_b[4*w+3], rx_b[4*w+2], rx_b[4*w+1], rx_b[4*w]};
        end
    end
endmodule

// File: rtl/i2c_burst_offload.sv
module i2c_burst_offload
    import i2cbo_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq,
    output logic          eng_cmd_valid,
    output logic [2:0]    eng_cmd_op,
    output logic [7:0]    eng_cmd_byte,
    output logic          eng_cmd_nack,
    input  logic          eng_rsp_valid,
    input  logic          eng_rsp_ack,
    input  logic [7:0]    eng_rsp_byte
);
    logic                go, go_rd, go_ten, seq_busy;
    logic [ADDR_W-1:0]   go_addr;
    logic [LEN_W-1:0]    go_len, rx_idx;
    logic [8*NBYTES-1:0] tx_bytes;
    logic                rx_we, done, fail, cause_q;
    logic [7:0]          rx_byte;
    logic [CTRL_W-1:0]   ctrl_q;

    i2cbo_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(seq_busy), .rx_we(rx_we), .rx_idx(rx_idx),
        .rx_byte(rx_byte), .done(done), .fail(fail), .go(go), .go_rd(go_rd),
        .go_ten(go_ten), .go_addr(go_addr), .go_len(go_len), .tx_bytes(tx_bytes),
        .ctrl_q(ctrl_q), .cause_q(cause_q), .irq(irq)
    );

    i2cbo_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .go_rd(go_rd), .go_ten(go_ten),
        .go_addr(go_addr), .go_len(go_len), .tx_bytes(tx_bytes),
        .cmd_valid(eng_cmd_valid), .cmd_op(eng_cmd_op), .cmd_byte(eng_cmd_byte),
        .cmd_nack(eng_cmd_nack), .rsp_valid(eng_rsp_valid), .rsp_ack(eng_rsp_ack),
        .rsp_byte(eng_rsp_byte), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
        .done(done), .fail(fail), .busy(seq_busy)
    );
endmodule

// File: rtl/i2cbo_chk.sv
module i2cbo_chk
    import i2cbo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              rsp_valid,
    input logic              reg_we,
    input logic              busy,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              cause_q
);
    AST_ONE_CMD_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R10
    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctrl_q)); // R8
    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we)); // R2
    AST_END_ON_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(rsp_valid)); // R3
    AST_CAUSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_q) |-> (($past(rsp_valid) && $past(busy)) || $past(reg_we))); // R7
endmodule

bind i2c_burst_offload i2cbo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(eng_cmd_valid), .rsp_valid(eng_rsp_valid),
    .reg_we(reg_we), .busy(seq_busy), .ctrl_q(ctrl_q), .cause_q(cause_q)
);

// File: tb/tb_i2c_burst_offload.sv
`timescale 1ns/1ps
module tb_i2c_burst_offload;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, eng_cmd_valid, eng_cmd_nack;
    logic [2:0]  eng_cmd_op;
    logic [7:0]  eng_cmd_byte;
    logic        eng_rsp_valid = 1'b0, eng_rsp_ack = 1'b0;
    logic [7:0]  eng_rsp_byte = '0;

    always #2.5 clk = ~clk;

    i2c_burst_offload dut (.*);

    int checks = 0, errors = 0;
    logic [11:0] exp_q[$];
    string cur_tag = "R1";
    int nack_at = -1, wr_seen = 0, rd_seen = 0, dly = 0;
    logic [2:0] last_op = 3'd0;
    logic ack_next = 1'b1;
    logic [7:0] byte_next = '0;
    logic m_cause = 1'b0, m_mask = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ent(input logic [2:0] op, input logic nk, input logic [7:0] b);
        return {op, nk, b};
    endfunction

    function automatic logic [31:0] mk(input bit w, input bit r, input bit ten,
                                       input int a, input int txl, input int rxl);
        return (32'd1 << 19) | (32'(rxl) << 16) | (32'(txl) << 13) | (32'(ten) << 12)
             | (32'(a) << 2) | (32'(r) << 1) | 32'(w);
    endfunction

    // engine model and command comparison
    always @(negedge clk) begin
        if (rst_n) begin
            eng_rsp_valid <= 1'b0;
            if (dly > 0) begin
                dly--;
                if (dly == 0) begin
                    eng_rsp_valid <= 1'b1;
                    eng_rsp_ack   <= ack_next;
                    eng_rsp_byte  <= byte_next;
                end
            end
            if (eng_cmd_valid) begin
                check(dly == 0, "R10 command before response", dly, 0);
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected command", {eng_cmd_op, eng_cmd_nack, eng_cmd_byte}, 0);
                end else begin
                    logic [11:0] e;
                    e = exp_q.pop_front();
                    check({eng_cmd_op, eng_cmd_nack, eng_cmd_byte} == e, cur_tag,
                          {eng_cmd_op, eng_cmd_nack, eng_cmd_byte}, e);
                end
                last_op = eng_cmd_op;
                dly = 2;
                ack_next = 1'b1;
                byte_next = '0;
                if (eng_cmd_op == 3'd2) begin
                    ack_next = (wr_seen != nack_at);
                    wr_seen++;
                end
                if (eng_cmd_op == 3'd3) begin
                    byte_next = 8'hA0 + 8'(rd_seen);
                    rd_seen++;
                end
            end
            // R7 interrupt model, compared every clock
            check(irq == (m_cause & m_mask), "R7 irq", irq, m_cause & m_mask);
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cause <= 1'b0;
            m_mask  <= 1'b0;
        end else begin
            if (eng_rsp_valid && last_op == 3'd4) m_cause <= 1'b1;
            else if (reg_we && reg_addr == 8'hD8) m_cause <= reg_wdata[0];
            if (reg_we && reg_addr == 8'hDC) m_mask <= reg_wdata[0];
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string req);
        logic [31:0] d;
        rd(a, d);
        check(d === e, req, d, e);
    endtask

    task automatic begin_xfer(input string tag, input int nk);
        exp_q.delete();
        cur_tag = tag; nack_at = nk; wr_seen = 0; rd_seen = 0;
    endtask

    task automatic wait_done(input string req);
        logic [31:0] d;
        int n = 0;
        do begin rd(8'hD8, d); n++; end while (d[0] == 1'b0 && n < 400);
        check(d[0] == 1'b1, req, d, 1);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic close_xfer();
        wr(8'hD0, 0);
        wr(8'hD8, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(eng_cmd_valid == 1'b0, "R1 cmd after reset", eng_cmd_valid, 0);
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        foreach (d[i]) ; // no-op keeps d used
        expect_reg(8'hC0, 0, "R1 tx low"); expect_reg(8'hC8, 0, "R1 rx low");
        expect_reg(8'hD0, 0, "R1 ctrl");   expect_reg(8'hD4, 0, "R1 status");
        expect_reg(8'hD8, 0, "R1 cause");  expect_reg(8'hDC, 0, "R1 mask");

        wr(8'hDC, 1);
        // R3 write, 7-bit, 3 bytes
        wr(8'hC0, 32'h44332211);
        begin_xfer("R3 write 3", -1);
        exp_q = '{ent(1,0,0), ent(2,0,8'hB4), ent(2,0,8'h11), ent(2,0,8'h22), ent(2,0,8'h33), ent(4,0,0)};
        wr(8'hD0, mk(1,0,0,'h5A,2,0));
        wait_done("R3 completion");
        expect_reg(8'hD4, 0, "R6 clean status");
        check(irq == 1'b1, "R7 irq set", irq, 1);
        close_xfer();
        check(irq == 1'b0, "R7 irq cleared", irq, 0);

        // R3 8-byte write with R8/R9 mid-transfer writes
        wr(8'hC0, 32'h03020100); wr(8'hC4, 32'h07060504);
        begin_xfer("R3 write 8", -1);
        exp_q.push_back(ent(1,0,0)); exp_q.push_back(ent(2,0,8'h0E));
        for (int k = 0; k < 8; k++) exp_q.push_back(ent(2,0,8'(k)));
        exp_q.push_back(ent(4,0,0));
        wr(8'hD0, mk(1,0,0,'h07,7,0));
        wr(8'hD0, mk(0,1,0,'h33,0,2));
        wr(8'hC0, 32'hDEADBEEF);
        expect_reg(8'hD0, mk(1,0,0,'h07,7,0), "R8 ctrl held");
        expect_reg(8'hC0, 32'h03020100, "R9 tx held");
        wait_done("R8 completion");
        close_xfer();

        // R4 read 5 bytes
        begin_xfer("R4 read 5", -1);
        exp_q = '{ent(1,0,0), ent(2,0,8'h27), ent(3,0,0), ent(3,0,0), ent(3,0,0), ent(3,0,0), ent(3,1,0), ent(4,0,0)};
        wr(8'hD0, mk(0,1,0,'h13,0,4));
        wait_done("R4 completion");
        expect_reg(8'hC8, 32'hA3A2A1A0, "R4 rx low");
        expect_reg(8'hCC, 32'h000000A4, "R4 rx high");
        close_xfer();

        // R5 10-bit write
        wr(8'hC0, 32'h0000BBAA);
        begin_xfer("R5 ten write", -1);
        exp_q = '{ent(1,0,0), ent(2,0,8'hF4), ent(2,0,8'hA5), ent(2,0,8'hAA), ent(2,0,8'hBB), ent(4,0,0)};
        wr(8'hD0, mk(1,0,1,'h2A5,1,0));
        wait_done("R5 completion");
        close_xfer();

        // R5 10-bit read
        begin_xfer("R5 ten read", -1);
        exp_q = '{ent(1,0,0), ent(2,0,8'hF2), ent(2,0,8'hC3), ent(1,0,0), ent(2,0,8'hF3), ent(3,1,0), ent(4,0,0)};
        wr(8'hD0, mk(0,1,1,'h1C3,0,0));
        wait_done("R5 read completion");
        expect_reg(8'hC8, 32'h000000A0, "R5 rx low");
        close_xfer();

        // R6 NACK on first data byte
        wr(8'hC0, 32'h44332211);
        begin_xfer("R6 data nack", 1);
        exp_q = '{ent(1,0,0), ent(2,0,8'hB4), ent(2,0,8'h11), ent(4,0,0)};
        wr(8'hD0, mk(1,0,0,'h5A,3,0));
        wait_done("R6 completion");
        expect_reg(8'hD4, 1, "R6 error status");
        close_xfer();

        // R6 NACK on read address; R4 results cleared
        begin_xfer("R6 addr nack", 0);
        exp_q = '{ent(1,0,0), ent(2,0,8'h27), ent(4,0,0)};
        wr(8'hD0, mk(0,1,0,'h13,0,3));
        wait_done("R6 addr completion");
        expect_reg(8'hD4, 1, "R6 addr error status");
        expect_reg(8'hC8, 0, "R4 rx cleared");
        close_xfer();

        // R2 invalid start words
        begin_xfer("R2", -1);
        wr(8'hD0, mk(1,1,0,'h10,0,0));
        wr(8'hD0, mk(1,0,0,'h10,0,0) & ~(32'd1 << 19));
        repeat (20) @(negedge clk);
        expect_reg(8'hD8, 0, "R2 no cause");
        expect_reg(8'hD4, 1, "R2 status untouched");
        wr(8'hD0, 0);

        // R6 clean transfer clears error
        begin_xfer("R6 clear", -1);
        exp_q = '{ent(1,0,0), ent(2,0,8'hB4), ent(2,0,8'h11), ent(4,0,0)};
        wr(8'hD0, mk(1,0,0,'h5A,0,0));
        wait_done("R6 clear completion");
        expect_reg(8'hD4, 0, "R6 status cleared");
        close_xfer();

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule